// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block runs the digital side of a successive-approximation analog-to-digital converter. The comparator and the DAC sit outside it. When a start request arrives while the block is idle, it does four things at once. It switches the front end into hold, enables the conversion clock, clears the approximation register and presents the MSB as the first trial code. Each bit period it reads a single comparator bit that says whether the trial code is still at or below the held input. It keeps or drops the trial bit on that answer and then moves one position toward the LSB.

The conversion length is chosen at start. It is either the full width or a short cycle that resolves only the upper bits. The choice is latched and exported so that a read interface can format the data. After the last decision the block stops the conversion clock and returns the front end to sampling. It emits a one-cycle end-of-conversion pulse and raises a data-valid enable. Busy stays high for a parameterised acquisition interval after that, and the result can already be read during it. Start requests are ignored for as long as busy is high.

Top module: `sar_conv_seq`

## Requirements
- R1: After reset, busy, holdCtl, convClkEn, dataValid, eocPulse and lastShort are 0, and trialCode and resultData are 0.
- R2: A start request sampled while idle gives busy=1, holdCtl=1 and convClkEn=1 from the next cycle. In that cycle trialCode holds only the MSB (0x800 at the default width of 12).
- R3: Decisions run from MSB to LSB, one every BIT_CYCLES clocks. compKeep=1 (trial code not above the input) keeps the trial bit and compKeep=0 clears it. A full conversion therefore ends with the largest code that is not above the input.
- R4: When shortSel=0 at start, all RES_BITS bits are trialled. holdCtl and convClkEn stay high for exactly RES_BITS*BIT_CYCLES cycles.
- R5: When shortSel=1 at start, only the upper SHORT_BITS bits are trialled, over SHORT_BITS*BIT_CYCLES cycles. The low RES_BITS-SHORT_BITS result bits stay 0.
- R6: A start request that arrives during the conversion or during the acquisition interval is ignored. It changes neither the length, the result nor lastShort, and it does not start a new conversion after busy falls.
- R7: Busy stays high for exactly ACQ_CYCLES cycles after holdCtl falls, and then drops.
- R8: dataValid is 0 while holdCtl is high. It rises in the cycle in which holdCtl falls and stays high, with resultData stable, until the next accepted start.
- R9: eocPulse is high for exactly one cycle per conversion, namely the first cycle after holdCtl falls.
- R10: lastShort takes the value shortSel had at the accepted start and holds it until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| startReq | input | 1 | Conversion start request; accepted only while idle |
| shortSel | input | 1 | 1 selects the short cycle, sampled with an accepted start |
| compKeep | input | 1 | Comparator result: 1 when the trial code is not above the held input |
| trialCode | output | RES_BITS | Code presented to the DAC |
| resultData | output | RES_BITS | Approximation register |
| holdCtl | output | 1 | 1 holds the front end, 0 lets it sample |
| convClkEn | output | 1 | Enable for the conversion clock |
| busy | output | 1 | Conversion or acquisition in progress |
| dataValid | output | 1 | resultData holds a finished conversion |
| eocPulse | output | 1 | One-cycle end-of-conversion flag |
| lastShort | output | 1 | Length of the last accepted conversion (1 = short) |

## Verification
A bit-timer or bit-mask fault changes the length of the holdCtl window, and the result word then differs from the binary search of the modelled input. Both are visible within one conversion, at most about a thousand cycles. The first trial code and the code after the first decision give an earlier view, within BIT_CYCLES+1 cycles of start. An acquisition-counter fault shifts the fall of busy relative to the rise of dataValid. A start gate that fails to block requests shows up as a changed length, a changed lastShort, or busy rising again right after the interval ends.

// File: rtl/sar_conv_seq_pkg.sv
package sar_conv_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CONV = 2'd1,
    ST_ACQ  = 2'd2
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clearSar;   // new conversion accepted
    logic decideBit;  // end of the current bit period
  } dpStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic lastBit;    // current trial bit is the final one
  } dpStatus_t;

endpackage

// File: rtl/sar_conv_seq_dp.sv
module sar_conv_seq_dp
  import sar_conv_seq_pkg::*;
#(
  parameter int RES_BITS   = 12,
  parameter int SHORT_BITS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  dpStrobe_t           strb,
  input  logic                shortSel,
  input  logic                compKeep,
  output dpStatus_t           stat,
  output logic [RES_BITS-1:0] trialCode,
  output logic [RES_BITS-1:0] resultData,
  output logic                lastShort
);

  localparam int DROP_BITS = RES_BITS - SHORT_BITS;
  localparam logic [RES_BITS-1:0] MSB_ONE = {1'b1, {(RES_BITS-1){1'b0}}};

  logic [RES_BITS-1:0] sarReg;
  logic [RES_BITS-1:0] bitMask;
  logic                shortLat;
  logic                shortStop;

  generate
    if (DROP_BITS > 0) begin : g_short
      assign shortStop = bitMask[DROP_BITS];
    end else begin : g_noshort
      assign shortStop = bitMask[0];
    end
  endgenerate

  assign stat.lastBit = shortLat ? shortStop : bitMask[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sarReg   <= '0;
      bitMask  <= '0;
      shortLat <= 1'b0;
    end else if (strb.clearSar) begin
      sarReg   <= '0;
      bitMask  <= MSB_ONE;
      shortLat <= shortSel;
    end else if (strb.decideBit) begin
      if (compKeep) sarReg <= sarReg | bitMask;
      // after the final decision the DAC sees the plain result
      if (stat.lastBit) bitMask <= '0;
      else              bitMask <= bitMask >> 1;
    end
  end

  assign trialCode  = sarReg | bitMask;
  assign resultData = sarReg;
  assign lastShort  = shortLat;

endmodule

// File: rtl/sar_conv_seq_ctrl.sv
module sar_conv_seq_ctrl
  import sar_conv_seq_pkg::*;
#(
  parameter int BIT_CYCLES = 75,
  parameter int ACQ_CYCLES = 100
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      startReq,
  input  dpStatus_t stat,
  output dpStrobe_t strb,
  output logic      holdCtl,
  output logic      convClkEn,
  output logic      busy,
  output logic      dataValid,
  output logic      eocPulse
);

  localparam int BTW = (BIT_CYCLES > 1) ? $clog2(BIT_CYCLES) : 1;
  localparam int ATW = (ACQ_CYCLES > 1) ? $clog2(ACQ_CYCLES) : 1;
  localparam logic [BTW-1:0] BIT_LAST = BTW'(BIT_CYCLES - 1);
  localparam logic [ATW-1:0] ACQ_LAST = ATW'(ACQ_CYCLES - 1);

  seqState_e      state;
  logic [BTW-1:0] bitTimer;
  logic [ATW-1:0] acqTimer;
  logic           validFlag;
  logic           eocReg;
  logic           bitEnd;

  assign bitEnd        = (state == ST_CONV) && (bitTimer == BIT_LAST);
  assign strb.clearSar = (state == ST_IDLE) && startReq;
  assign strb.decideBit = bitEnd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      bitTimer  <= '0;
      acqTimer  <= '0;
      validFlag <= 1'b0;
      eocReg    <= 1'b0;
    end else begin
      eocReg <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (startReq) begin
            state     <= ST_CONV;
            bitTimer  <= '0;
            validFlag <= 1'b0;
          end
        end
        ST_CONV: begin
          if (bitEnd) begin
            bitTimer <= '0;
            if (stat.lastBit) begin
              state     <= ST_ACQ;
              acqTimer  <= '0;
              validFlag <= 1'b1;
              eocReg    <= 1'b1;
            end
          end else begin
            bitTimer <= bitTimer + 1'b1;
          end
        end
        ST_ACQ: begin
          if (acqTimer == ACQ_LAST) state <= ST_IDLE;
          else                      acqTimer <= acqTimer + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign holdCtl   = (state == ST_CONV);
  assign convClkEn = (state == ST_CONV);
  assign busy      = (state != ST_IDLE);
  assign dataValid = validFlag;
  assign eocPulse  = eocReg;

endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq
  import sar_conv_seq_pkg::*;
#(
  parameter int RES_BITS   = 12,
  parameter int SHORT_BITS = 8,
  parameter int BIT_CYCLES = 75,
  parameter int ACQ_CYCLES = 100
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                startReq,
  input  logic                shortSel,
  input  logic                compKeep,
  output logic [RES_BITS-1:0] trialCode,
  output logic [RES_BITS-1:0] resultData,
  output logic                holdCtl,
  output logic                convClkEn,
  output logic                busy,
  output logic                dataValid,
  output logic                eocPulse,
  output logic                lastShort
);

  dpStrobe_t strb;
  dpStatus_t stat;

  sar_conv_seq_ctrl #(
    .BIT_CYCLES(BIT_CYCLES),
    .ACQ_CYCLES(ACQ_CYCLES)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .startReq (startReq),
    .stat     (stat),
    .strb     (strb),
    .holdCtl  (holdCtl),
    .convClkEn(convClkEn),
    .busy     (busy),
    .dataValid(dataValid),
    .eocPulse (eocPulse)
  );

  sar_conv_seq_dp #(
    .RES_BITS  (RES_BITS),
    .SHORT_BITS(SHORT_BITS)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strb      (strb),
    .shortSel  (shortSel),
    .compKeep  (compKeep),
    .stat      (stat),
    .trialCode (trialCode),
    .resultData(resultData),
    .lastShort (lastShort)
  );

endmodule

// File: rtl/sar_conv_seq_chk.sv
module sar_conv_seq_chk #(
  parameter int RES_BITS   = 12,
  parameter int SHORT_BITS = 8,
  parameter int ACQ_CYCLES = 100
) (
  input logic                clk,
  input logic                rst_n,
  input logic                startReq,
  input logic [RES_BITS-1:0] trialCode,
  input logic [RES_BITS-1:0] resultData,
  input logic                holdCtl,
  input logic                busy,
  input logic                dataValid,
  input logic                eocPulse,
  input logic                lastShort
);

  localparam int DROP_BITS = RES_BITS - SHORT_BITS;
  localparam logic [RES_BITS-1:0] MSB_ONE = {1'b1, {(RES_BITS-1){1'b0}}};
  localparam logic [RES_BITS-1:0] LOW_MASK = (RES_BITS)'((1 << DROP_BITS) - 1);

  logic [31:0] acqSeen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       acqSeen <= '0;
    else if (holdCtl) acqSeen <= '0;
    else if (busy)    acqSeen <= acqSeen + 1;
  end

  AST_START_ENTERS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && startReq) |=> (busy && holdCtl && trialCode == MSB_ONE)); // R2

  AST_NO_VALID_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    holdCtl |-> !dataValid); // R8

  AST_RESULT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (dataValid && $past(dataValid)) |-> $stable(resultData)); // R8

  AST_EOC_AFTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(holdCtl) |-> (eocPulse && dataValid && busy)); // R9

  AST_EOC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    eocPulse |=> !eocPulse); // R9

  AST_SHORT_LSB_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (lastShort && dataValid) |-> ((resultData & LOW_MASK) == '0)); // R5

  AST_LEN_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy || $stable(lastShort))); // R10

  AST_ACQ_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (acqSeen == ACQ_CYCLES)); // R7

  AST_BUSY_NO_STEAL: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !holdCtl && startReq) |=> !holdCtl); // R6

endmodule

bind sar_conv_seq sar_conv_seq_chk #(
  .RES_BITS  (RES_BITS),
  .SHORT_BITS(SHORT_BITS),
  .ACQ_CYCLES(ACQ_CYCLES)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .startReq  (startReq),
  .trialCode (trialCode),
  .resultData(resultData),
  .holdCtl   (holdCtl),
  .busy      (busy),
  .dataValid (dataValid),
  .eocPulse  (eocPulse),
  .lastShort (lastShort)
);

// File: tb/sar_conv_seq_tb.sv
module sar_conv_seq_tb;

  localparam int RB  = 12;
  localparam int SB  = 8;
  localparam int BC  = 75;
  localparam int AC  = 100;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          startReq = 1'b0;
  logic          shortSel = 1'b0;
  logic          compKeep;
  logic [RB-1:0] trialCode, resultData;
  logic          holdCtl, convClkEn, busy, dataValid, eocPulse, lastShort;
  logic [RB-1:0] vin = '0;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  // external comparator: keep the bit while the DAC code is not above the input
  assign compKeep = (trialCode <= vin);

  sar_conv_seq #(
    .RES_BITS(RB), .SHORT_BITS(SB), .BIT_CYCLES(BC), .ACQ_CYCLES(AC)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .startReq(startReq), .shortSel(shortSel),
    .compKeep(compKeep), .trialCode(trialCode), .resultData(resultData),
    .holdCtl(holdCtl), .convClkEn(convClkEn), .busy(busy),
    .dataValid(dataValid), .eocPulse(eocPulse), .lastShort(lastShort)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic testReset();
    check(!busy && !holdCtl && !convClkEn, "R1", "status idle",
          {busy, holdCtl, convClkEn}, 0);
    check(!dataValid && !eocPulse && !lastShort, "R1", "flags clear",
          {dataValid, eocPulse, lastShort}, 0);
    check(trialCode == 0 && resultData == 0, "R1", "codes zero",
          {trialCode, resultData}, 0);
  endtask

  // one conversion; optional start pulses while busy
  task automatic runConv(input logic [RB-1:0] v, input bit shortMode,
                         input bit poke);
    int nBits  = shortMode ? SB : RB;
    int holdExp = nBits * BC;
    int total  = holdExp + AC;
    int n = 0, holdCnt = 0, validCnt = 0, eocCnt = 0, badValid = 0;
    logic [RB-1:0] expRes;
    logic [RB-1:0] expSecond;
    string lenReq = shortMode ? "R5" : "R4";
    expRes    = shortMode ? {v[RB-1:RB-SB], {(RB-SB){1'b0}}} : v;
    expSecond = v[RB-1] ? 12'hC00 : 12'h400;

    @(negedge clk);
    vin = v; shortSel = shortMode; startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0; shortSel = ~shortMode;
    while (busy && n < 4000) begin
      if (n == 0) begin
        check(holdCtl && convClkEn, "R2", "hold and clock on", {holdCtl, convClkEn}, 3);
        check(trialCode == 12'h800, "R2", "first trial MSB", trialCode, 12'h800);
      end
      if (n == BC)
        check(trialCode == expSecond, "R3", "trial after first decision",
              trialCode, expSecond);
      if (holdCtl) holdCnt++;
      if (holdCtl && dataValid) badValid++;
      if (dataValid && !holdCtl) validCnt++;
      if (eocPulse) eocCnt++;
      startReq = poke && (n == 20 || n == holdExp + 5 || n == total - 1);
      n++;
      @(negedge clk);
    end
    startReq = 1'b0;
    check(holdCnt == holdExp, lenReq, "hold window length", holdCnt, holdExp);
    check(n == total, "R7", "busy length", n, total);
    check(validCnt == AC, "R8", "valid ahead of busy fall", validCnt, AC);
    check(badValid == 0, "R8", "valid while holding", badValid, 0);
    check(eocCnt == 1, "R9", "eoc pulse count", eocCnt, 1);
    check(resultData == expRes, shortMode ? "R5" : "R3", "result", resultData, expRes);
    check(dataValid, "R8", "valid kept in idle", dataValid, 1);
    check(lastShort == shortMode, "R10", "latched length", lastShort, shortMode);
    if (poke) begin
      @(negedge clk);
      check(!busy && !holdCtl, "R6", "no restart after late start",
            {busy, holdCtl}, 0);
      check(resultData == expRes && lastShort == shortMode, "R6",
            "result kept under restart", resultData, expRes);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rst_n = 1'b1;
    @(negedge clk);
    testReset();
    runConv(12'h000, 1'b0, 1'b0);
    runConv(12'hFFF, 1'b0, 1'b0);
    runConv(12'h800, 1'b0, 1'b0);
    runConv(12'h7FF, 1'b0, 1'b0);
    runConv(12'hA5C, 1'b0, 1'b1);
    runConv(12'hABC, 1'b1, 1'b0);
    runConv(12'hFFF, 1'b1, 1'b1);
    runConv(12'h3C7, 1'b0, 1'b0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule